// File: doc/BRIEF.md
# Block Cipher Sequencer and Handshake Controller

This block is the control layer between a register interface and a 128-bit block cipher datapath. Software writes up to eight 32-bit key words and four 32-bit input words into holding registers. It also writes a control word that selects the direction, the key length and two policy bits. The controller decides when a block begins. In automatic mode a block begins as soon as all four input words are fresh. In manual mode a block begins only on an explicit trigger. When a block begins, the controller copies the key and the input into the datapath-facing registers and emits a one-cycle start strobe.

The datapath is modelled as a fixed latency of `LAT` cycles. On the final cycle the controller either commits the datapath result into the output words, or it stalls. It stalls when the previous result has not been read and overwriting is not permitted. A four-bit status word reports idle, stall, output valid and input ready. The key-length selector is sanitised whenever the control word is written, so that the datapath only ever sees a legal one-hot length.

Top module: `cipher_ctrl`

## Requirements
- R1: The control word holds mode in bit 0 (1 = decrypt), a one-hot key length in bits 3:1 (001 = 128, 010 = 192, 100 = 256), manual start in bit 4 and overwrite-allowed in bit 5. The key-length field resets to 001. Any written value other than 001 or 100 reads back as 001. The exception is 010, which is kept when `SUPPORT_192` is 1.
- R2: A key word write takes effect only while status bit 0 (idle) is 1. The stored key words appear on `dp_key` (word i at bits 32i+31:32i) from the cycle in which a block begins.
- R3: The input words appear on `dp_state` (word i at bits 32i+31:32i) when a block begins. Status bit 3 (input ready) resets to 1. It reads 0 from the cycle after any input write until the block that takes that input begins.
- R4: With manual start 0, a block begins in the cycle after the last of the four input words has been written since the previous load. `dp_start` is 1 for exactly that one cycle, and status bit 0 reads 0 from then on.
- R5: With manual start 1, fresh input alone never begins a block. Writing trigger value 1 begins a block one cycle later, and the trigger reads back 0 from the cycle the block begins.
- R6: `LAT` cycles after `dp_start`, an unstalled block sets `dout` to `dp_result`, sets status bit 2 (output valid) and returns status bit 0 to 1.
- R7: With overwrite disabled and output valid still set on the final cycle, status bit 1 (stall) is 1 and `dout` is held. The block stays busy until the output has been read. It then commits one cycle after output valid clears.
- R8: With overwrite enabled, a block commits after exactly `LAT` cycles even when the previous output is unread, and the stall bit stays 0.
- R9: Output valid clears in the cycle after every one of the four `dout_re` strobes has been seen since the output was written, in any order and over any number of cycles. Output valid stays set while any word is still unread.
- R10: `dp_decrypt` and `dp_key_len` are captured when a block begins and do not follow control writes made while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 3 | Key word index |
| key_wdata | input | 32 | Key word value |
| din_we | input | 1 | Input word write strobe |
| din_idx | input | 2 | Input word index |
| din_wdata | input | 32 | Input word value |
| dout_re | input | 4 | Per-word read strobes of the output |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word value |
| trig_we | input | 1 | Trigger write strobe |
| trig_wdata | input | 1 | Trigger value |
| dp_result | input | 128 | Result presented by the datapath |
| status | output | 4 | {input ready, output valid, stall, idle} |
| ctrl_q | output | 6 | Control word readback (sanitised) |
| trig_q | output | 1 | Trigger readback |
| dout | output | 128 | Output words |
| dp_start | output | 1 | One-cycle start/load strobe to the datapath |
| dp_decrypt | output | 1 | Direction captured at start |
| dp_key_len | output | 3 | Key length captured at start |
| dp_key | output | 256 | Key words loaded at start |
| dp_state | output | 128 | Input words loaded at start |

## Verification
The embedded assertions take for granted that an input word is never written in the same cycle as a load. In that cycle the load and the write would both claim the word's fresh flag. The assertions also take for granted that indexes stay in range. The bench writes input only while idle, or well after `dp_start` has been seen. It pulses each strobe for a single cycle and changes inputs half a cycle away from the active edge. Read strobes are issued one word at a time, so output-valid clearing is observed across several cycles.

// File: rtl/cc_pkg.sv
// Shared types and the key-length sanitiser for the cipher control block.
// Assumes one-hot encodings 001/010/100 for 128/192/256-bit keys.
package cc_pkg;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_t;

    typedef struct packed {
        logic       force_ovw;
        logic       manual;
        logic [2:0] klen;
        logic       decrypt;
    } ctrl_t;

    // Map an arbitrary 3-bit length request onto a legal one-hot code.
    function automatic logic [2:0] fix_klen(input logic [2:0] req, input logic en192);
        logic [2:0] res;
        res = 3'b001;
        if (req == 3'b100)               res = 3'b100;
        else if (req == 3'b010 && en192) res = 3'b010;
        return res;
    endfunction

endpackage

// File: rtl/cc_cfg.sv
// Control word and trigger storage. Sanitises the key length on every write
// and clears the trigger when a block begins. Assumes go is a one-cycle flag.
module cc_cfg
    import cc_pkg::*;
#(
    parameter bit SUPPORT_192 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [5:0] ctrl_wdata,
    input  logic       trig_we,
    input  logic       trig_wdata,
    input  logic       go,
    output ctrl_t      cfg,
    output logic       trig_q
);

    // Control register with sanitised length field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{force_ovw: 1'b0, manual: 1'b0, klen: 3'b001, decrypt: 1'b0};
        end else if (ctrl_we) begin
            cfg.decrypt   <= ctrl_wdata[0];
            cfg.klen      <= fix_klen(ctrl_wdata[3:1], SUPPORT_192);
            cfg.manual    <= ctrl_wdata[4];
            cfg.force_ovw <= ctrl_wdata[5];
        end
    end

    // Trigger bit: hardware clear on block start wins over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_q <= 1'b0;
        else if (go)      trig_q <= 1'b0;
        else if (trig_we) trig_q <= trig_wdata;
    end

    p_klen_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cfg.klen) && (SUPPORT_192 || cfg.klen != 3'b010));

endmodule

// File: rtl/cc_inbuf.sv
// Key and input holding registers, per-word fresh flags, and the
// datapath-facing copies loaded on block start. Assumes indexes in range.
module cc_inbuf #(
    parameter int WORD_W     = 32,
    parameter int KEY_WORDS  = 8,
    parameter int DATA_WORDS = 4,
    localparam int KIW = $clog2(KEY_WORDS),
    localparam int DIW = $clog2(DATA_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         key_we,
    input  logic [KIW-1:0]               key_idx,
    input  logic [WORD_W-1:0]            key_wdata,
    input  logic                         din_we,
    input  logic [DIW-1:0]               din_idx,
    input  logic [WORD_W-1:0]            din_wdata,
    input  logic                         idle,
    input  logic                         load,
    output logic [KEY_WORDS*WORD_W-1:0]  full_key,
    output logic [DATA_WORDS*WORD_W-1:0] state_q,
    output logic                         all_written,
    output logic                         input_ready
);

    logic [KEY_WORDS-1:0][WORD_W-1:0]  key_q;
    logic [DATA_WORDS-1:0][WORD_W-1:0] din_q;
    logic [DATA_WORDS-1:0]             fresh_q;

    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        // Key word k: written only while idle.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  key_q[k] <= '0;
            else if (key_we && idle && key_idx == KIW'(k)) key_q[k] <= key_wdata;
        end
    end

    for (genvar d = 0; d < DATA_WORDS; d++) begin : g_din
        // Input word d and its fresh flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                din_q[d]   <= '0;
                fresh_q[d] <= 1'b0;
            end else if (din_we && din_idx == DIW'(d)) begin
                din_q[d]   <= din_wdata;
                fresh_q[d] <= 1'b1;
            end else if (load) begin
                fresh_q[d] <= 1'b0;
            end
        end
    end

    // Datapath-facing copies taken at block start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_key <= '0;
            state_q  <= '0;
        end else if (load) begin
            full_key <= key_q;
            state_q  <= din_q;
        end
    end

    assign all_written = &fresh_q;
    assign input_ready = ~|fresh_q;

    p_key_frozen_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(key_q));
    p_ready_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (din_we && !load) |=> !input_ready);

endmodule

// File: rtl/cc_seq.sv
// Block sequencer: start decision, latency counter modelling the datapath,
// and the stall-or-commit choice on the final cycle. Assumes LAT >= 1.
module cc_seq
    import cc_pkg::*;
#(
    parameter int LAT = 4,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t cfg,
    input  logic  trig_q,
    input  logic  all_written,
    input  logic  out_valid,
    output logic  go,
    output logic  idle,
    output logic  stall,
    output logic  commit,
    output logic  dp_start
);

    seq_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic          last_cyc;
    logic          blocked;

    assign idle     = (st_q == ST_IDLE);
    assign go       = idle && (cfg.manual ? trig_q : all_written);
    assign last_cyc = (st_q == ST_BUSY) && (cnt_q == '0);
    assign blocked  = out_valid && !cfg.force_ovw;
    assign stall    = last_cyc && blocked;
    assign commit   = last_cyc && !blocked;

    // State and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (go) begin
            st_q  <= ST_BUSY;
            cnt_q <= CW'(LAT - 1);
        end else if (commit) begin
            st_q  <= ST_IDLE;
        end else if (st_q == ST_BUSY && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Registered start strobe, high in the first busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dp_start <= 1'b0;
        else        dp_start <= go;
    end

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> !idle);
    p_stall_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !idle);

endmodule

// File: rtl/cc_outbuf.sv
// Output words, output-valid flag and per-word read tracking.
// Assumes commit is a one-cycle flag; reads while not valid are ignored.
module cc_outbuf #(
    parameter int WORD_W     = 32,
    parameter int DATA_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [DATA_WORDS*WORD_W-1:0] result,
    input  logic [DATA_WORDS-1:0]        rd_stb,
    output logic [DATA_WORDS*WORD_W-1:0] dout,
    output logic                         out_valid
);

    logic [DATA_WORDS-1:0] seen_q;
    logic                  all_seen;

    assign all_seen = &(seen_q | rd_stb);

    // Commit, then track reads until every word has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
            seen_q    <= '0;
        end else if (commit) begin
            dout      <= result;
            out_valid <= 1'b1;
            seen_q    <= '0;
        end else if (out_valid && all_seen) begin
            out_valid <= 1'b0;
            seen_q    <= '0;
        end else if (out_valid) begin
            seen_q    <= seen_q | rd_stb;
        end
    end

    p_valid_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> out_valid);
    p_valid_needs_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !commit && !all_seen) |=> out_valid);

endmodule

// File: rtl/cipher_ctrl.sv
// Top of the block cipher control unit. Ties configuration, input holding,
// sequencing and output tracking together and latches direction and key
// length at block start. Assumes a datapath whose result is valid on commit.
module cipher_ctrl
    import cc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int KEY_WORDS   = 8,
    parameter int DATA_WORDS  = 4,
    parameter int LAT         = 4,
    parameter bit SUPPORT_192 = 1'b1,
    localparam int KIW = $clog2(KEY_WORDS),
    localparam int DIW = $clog2(DATA_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         key_we,
    input  logic [KIW-1:0]               key_idx,
    input  logic [WORD_W-1:0]            key_wdata,
    input  logic                         din_we,
    input  logic [DIW-1:0]               din_idx,
    input  logic [WORD_W-1:0]            din_wdata,
    input  logic [DATA_WORDS-1:0]        dout_re,
    input  logic                         ctrl_we,
    input  logic [5:0]                   ctrl_wdata,
    input  logic                         trig_we,
    input  logic                         trig_wdata,
    input  logic [DATA_WORDS*WORD_W-1:0] dp_result,
    output logic [3:0]                   status,
    output logic [5:0]                   ctrl_q,
    output logic                         trig_q,
    output logic [DATA_WORDS*WORD_W-1:0] dout,
    output logic                         dp_start,
    output logic                         dp_decrypt,
    output logic [2:0]                   dp_key_len,
    output logic [KEY_WORDS*WORD_W-1:0]  dp_key,
    output logic [DATA_WORDS*WORD_W-1:0] dp_state
);

    ctrl_t cfg;
    logic  go, idle, stall, commit, out_valid, all_written, input_ready;

    cc_cfg #(.SUPPORT_192(SUPPORT_192)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .go(go),
        .cfg(cfg), .trig_q(trig_q)
    );

    cc_inbuf #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .DATA_WORDS(DATA_WORDS)) u_inbuf (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx),
        .key_wdata(key_wdata), .din_we(din_we), .din_idx(din_idx),
        .din_wdata(din_wdata), .idle(idle), .load(go), .full_key(dp_key),
        .state_q(dp_state), .all_written(all_written), .input_ready(input_ready)
    );

    cc_seq #(.LAT(LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .trig_q(trig_q),
        .all_written(all_written), .out_valid(out_valid), .go(go),
        .idle(idle), .stall(stall), .commit(commit), .dp_start(dp_start)
    );

    cc_outbuf #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS)) u_outbuf (
        .clk(clk), .rst_n(rst_n), .commit(commit), .result(dp_result),
        .rd_stb(dout_re), .dout(dout), .out_valid(out_valid)
    );

    // Direction and key length frozen for the duration of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_decrypt <= 1'b0;
            dp_key_len <= 3'b001;
        end else if (go) begin
            dp_decrypt <= cfg.decrypt;
            dp_key_len <= cfg.klen;
        end
    end

    assign ctrl_q = {cfg.force_ovw, cfg.manual, cfg.klen, cfg.decrypt};
    assign status = {input_ready, out_valid, stall, idle};

    p_trig_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> !trig_q);
    p_stall_holds_dout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(dout));
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !dp_start) |-> ($stable(dp_decrypt) && $stable(dp_key_len)));

endmodule

// File: tb/sim_cipher_ctrl.sv
// Directed bench for cipher_ctrl: one task per scenario.
module sim_cipher_ctrl;

    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_we = 1'b0;
    logic [2:0]   key_idx = '0;
    logic [31:0]  key_wdata = '0;
    logic         din_we = 1'b0;
    logic [1:0]   din_idx = '0;
    logic [31:0]  din_wdata = '0;
    logic [3:0]   dout_re = '0;
    logic         ctrl_we = 1'b0;
    logic [5:0]   ctrl_wdata = '0;
    logic         trig_we = 1'b0;
    logic         trig_wdata = 1'b0;
    logic [127:0] dp_result = '0;

    logic [3:0]   status, status1;
    logic [5:0]   ctrl_q, ctrl_q1;
    logic         trig_q, trig_q1;
    logic [127:0] dout, dout1, dp_state, dp_state1;
    logic         dp_start, dp_start1, dp_decrypt, dp_decrypt1;
    logic [2:0]   dp_key_len, dp_key_len1;
    logic [255:0] dp_key, dp_key1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cipher_ctrl #(.LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx),
        .key_wdata(key_wdata), .din_we(din_we), .din_idx(din_idx),
        .din_wdata(din_wdata), .dout_re(dout_re), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .dp_result(dp_result), .status(status), .ctrl_q(ctrl_q), .trig_q(trig_q),
        .dout(dout), .dp_start(dp_start), .dp_decrypt(dp_decrypt),
        .dp_key_len(dp_key_len), .dp_key(dp_key), .dp_state(dp_state)
    );

    cipher_ctrl #(.LAT(LAT), .SUPPORT_192(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(key_idx),
        .key_wdata(key_wdata), .din_we(din_we), .din_idx(din_idx),
        .din_wdata(din_wdata), .dout_re(dout_re), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .dp_result(dp_result), .status(status1), .ctrl_q(ctrl_q1), .trig_q(trig_q1),
        .dout(dout1), .dp_start(dp_start1), .dp_decrypt(dp_decrypt1),
        .dp_key_len(dp_key_len1), .dp_key(dp_key1), .dp_state(dp_state1)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_key(input int i, input logic [31:0] v);
        @(negedge clk); key_we = 1'b1; key_idx = 3'(i); key_wdata = v;
        @(negedge clk); key_we = 1'b0;
    endtask

    task automatic wr_din(input int i, input logic [31:0] v);
        @(negedge clk); din_we = 1'b1; din_idx = 2'(i); din_wdata = v;
        @(negedge clk); din_we = 1'b0;
    endtask

    task automatic wr_block(input logic [127:0] v);
        for (int i = 0; i < 4; i++) wr_din(i, v[32*i +: 32]);
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic rd_word(input int i);
        @(negedge clk); dout_re = 4'b0001 << i;
        @(negedge clk); dout_re = '0;
    endtask

    task automatic t_reset();
        chk("R3 reset status", 256'(status), 256'(4'b1001));
        chk("R1 reset ctrl", 256'(ctrl_q), 256'(6'b000010));
        chk("R5 reset trig", 256'(trig_q), 256'(0));
    endtask

    task automatic t_klen();
        for (int v = 0; v < 8; v++) begin
            logic [2:0] e0, e1;
            e0 = (v == 1 || v == 2 || v == 4) ? 3'(v) : 3'b001;
            e1 = (v == 1 || v == 4) ? 3'(v) : 3'b001;
            wr_ctrl({2'b00, 3'(v), 1'b0});
            chk("R1 klen 192 on", 256'(ctrl_q[3:1]), 256'(e0));
            chk("R1 klen 192 off", 256'(ctrl_q1[3:1]), 256'(e1));
        end
    endtask

    task automatic t_auto(input logic [255:0] key, input logic [127:0] blk, input logic [127:0] res);
        wr_ctrl(6'b000010);
        for (int i = 0; i < 8; i++) wr_key(i, key[32*i +: 32]);
        dp_result = res;
        wr_block(blk);
        chk("R3 ready low after input", 256'(status[3]), 256'(0));
        @(negedge clk);
        chk("R4 start pulse", 256'(dp_start), 256'(1));
        chk("R4 busy", 256'(status[0]), 256'(0));
        chk("R3 state loaded", 256'(dp_state), 256'(blk));
        chk("R2 key loaded", dp_key, key);
        chk("R3 ready back", 256'(status[3]), 256'(1));
        @(negedge clk);
        chk("R4 single pulse", 256'(dp_start), 256'(0));
        repeat (LAT - 2) @(negedge clk);
        chk("R6 still busy", 256'(status[0]), 256'(0));
        @(negedge clk);
        chk("R6 idle", 256'(status[0]), 256'(1));
        chk("R6 valid", 256'(status[2]), 256'(1));
        chk("R6 dout", 256'(dout), 256'(res));
    endtask

    task automatic t_stall(input logic [127:0] old_res, input logic [127:0] res);
        dp_result = res;
        wr_block(128'h1111_2222_3333_4444_5555_6666_7777_8888);
        @(negedge clk);
        chk("R4 stall block started", 256'(dp_start), 256'(1));
        wr_key(0, 32'hBAD0_BAD0);
        repeat (LAT + 2) @(negedge clk);
        chk("R7 stall bit", 256'(status[1]), 256'(1));
        chk("R7 busy while stalled", 256'(status[0]), 256'(0));
        chk("R7 dout held", 256'(dout), 256'(old_res));
        rd_word(2); rd_word(0); rd_word(3);
        chk("R9 valid with one unread", 256'(status[2]), 256'(1));
        rd_word(1);
        chk("R9 valid cleared", 256'(status[2]), 256'(0));
        chk("R7 stall released", 256'(status[1]), 256'(0));
        @(negedge clk);
        chk("R7 commit after read", 256'(dout), 256'(res));
        chk("R7 idle after commit", 256'(status[0]), 256'(1));
    endtask

    task automatic t_force(input logic [31:0] key0, input logic [127:0] res);
        wr_ctrl(6'b100010);
        dp_result = res;
        wr_block(128'hA5A5);
        @(negedge clk);
        chk("R2 busy key write ignored", 256'(dp_key[31:0]), 256'(key0));
        repeat (LAT - 1) @(negedge clk);
        chk("R8 no stall", 256'(status[1]), 256'(0));
        @(negedge clk);
        chk("R8 overwritten", 256'(dout), 256'(res));
        chk("R8 idle", 256'(status[0]), 256'(1));
    endtask

    task automatic t_manual();
        wr_ctrl(6'b111001);
        wr_block(128'hC0FFEE);
        repeat (3) @(negedge clk);
        chk("R5 no auto start", 256'(status[0]), 256'(1));
        @(negedge clk); trig_we = 1'b1; trig_wdata = 1'b1;
        @(negedge clk); trig_we = 1'b0;
        chk("R5 trig set", 256'(trig_q), 256'(1));
        chk("R5 idle before start", 256'(status[0]), 256'(1));
        @(negedge clk);
        chk("R5 started", 256'(dp_start), 256'(1));
        chk("R5 trig self-clear", 256'(trig_q), 256'(0));
        chk("R10 decrypt captured", 256'(dp_decrypt), 256'(1));
        chk("R10 klen captured", 256'(dp_key_len), 256'(3'b100));
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 6'b110010;
        @(negedge clk); ctrl_we = 1'b0;
        chk("R10 decrypt frozen", 256'(dp_decrypt), 256'(1));
        chk("R10 klen frozen", 256'(dp_key_len), 256'(3'b100));
        repeat (LAT + 2) @(negedge clk);
        chk("R5 block done", 256'(status[0]), 256'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_klen();
        t_auto({8{32'h0123_4567}} ^ 256'h0F0E0D0C, 128'hDEAD_BEEF_0000_1111, 128'hAAAA_0001);
        t_stall(128'hAAAA_0001, 128'hBBBB_0002);
        t_force(32'h0123_4567 ^ 32'h0F0E0D0C, 128'hCCCC_0003);
        t_manual();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule